// File: doc/BRIEF.md
# Two-Way Latched/Registered Bus Transceiver

This block moves an 18-bit word between two ports, A and B. Each direction has its own holding stage and its own output stage. The A-to-B path takes its word from `a_in` and presents it on `b_out`. The B-to-A path takes its word from `b_in` and presents it on `a_out`.

Each direction has four controls:
- a level-sensitive pass-through enable (`*_pass`);
- a capture strobe (`*_strobe`), whose rising edge stores the input word;
- an active-low strobe qualifier (`*_hold_n`);
- an active-low drive enable (`*_drv_n`).

Pass-through takes priority over the strobe path. With pass-through low, the stage keeps its word until a qualified strobe edge arrives.

On chip, the three-state pads become a data vector plus a per-bit drive-enable vector. All controls are sampled by one core clock. A strobe edge is seen as a low-to-high change of the strobe between two core clock cycles. The stored word changes at the core clock edge that samples the pass-through level or the qualified strobe edge.

Top module: `ubt_transceiver`

## Requirements
- R1: With a direction's `*_drv_n` high, that direction's drive-enable vector is all zeros and its data output is all zeros, whatever its other controls and inputs are.
- R2: With `*_pass` high and the direction enabled, the output equals the opposite port's input in the same cycle. The strobe and qualifier have no effect during this time.
- R3: With `*_pass` low and `*_hold_n` low, a strobe that is high in a cycle and was low in the previous cycle stores that cycle's input word. The word appears on the output from the next cycle onward.
- R4: With `*_pass` low and `*_hold_n` high, the stored word stays unchanged even when the strobe rises.
- R5: With `*_pass` low and the strobe held steady, either high or low, the stored word stays unchanged while the input data changes.
- R6: When `*_pass` falls, the stage keeps the word that was input in the last cycle with `*_pass` high. A strobe rise that happened while `*_pass` was high does not count as a capture edge later on.
- R7: Toggling `*_drv_n` never changes the stored word. A direction with its drive disabled still passes through and captures, so enabling it later shows the latest word.
- R8: The two directions are independent. The controls and input of one direction never change the other direction's output.
- R9: After reset the stored words are zero. The strobe counts as high at reset, so a strobe that is already high when reset releases gives no capture.
- R10: All bits of a direction share one set of controls. Each drive-enable vector is either all ones or all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock sampling all controls |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_in | input | 18 | Word arriving on port A |
| a_out | output | 18 | Word driven onto port A (B-to-A path) |
| a_oe | output | 18 | Per-bit drive enable for port A |
| b_in | input | 18 | Word arriving on port B |
| b_out | output | 18 | Word driven onto port B (A-to-B path) |
| b_oe | output | 18 | Per-bit drive enable for port B |
| ab_drv_n | input | 1 | A-to-B drive enable, active low |
| ab_pass | input | 1 | A-to-B pass-through enable |
| ab_strobe | input | 1 | A-to-B capture strobe |
| ab_hold_n | input | 1 | A-to-B strobe qualifier, active low |
| ba_drv_n | input | 1 | B-to-A drive enable, active low |
| ba_pass | input | 1 | B-to-A pass-through enable |
| ba_strobe | input | 1 | B-to-A capture strobe |
| ba_hold_n | input | 1 | B-to-A strobe qualifier, active low |

## Verification
The assertions assume that every control and data input is synchronous to the core clock and settles between its edges. They also assume that a strobe edge is therefore a change of level from one core cycle to the next. The stimulus changes inputs only on the falling edge of the core clock, and it toggles each strobe no faster than once per cycle. The qualifier and data are applied in the same cycle as the strobe rise they belong to, so they are sampled together with that edge.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    typedef enum logic [1:0] {
        ACT_KEEP    = 2'd0,
        ACT_FOLLOW  = 2'd1,
        ACT_CAPTURE = 2'd2
    } store_act_e;

    // Pass-through wins over the strobe path; a strobe edge only counts
    // when the active-low qualifier is asserted.
    function automatic store_act_e pick_act(input logic pass,
                                            input logic hold_n,
                                            input logic rise);
        store_act_e act;
        if (pass)
            act = ACT_FOLLOW;
        else if (rise && !hold_n)
            act = ACT_CAPTURE;
        else
            act = ACT_KEEP;
        return act;
    endfunction

endpackage

// File: rtl/ubt_edge_det.sv
module ubt_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    typedef struct packed {
        logic lvl_seen;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.lvl_seen = lvl;
    end

    // Reset to high so a strobe already high at release is not an edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{lvl_seen: 1'b1};
        else
            st_q <= st_d;
    end

    assign rise = lvl & ~st_q.lvl_seen;

endmodule

// File: rtl/ubt_store.sv
module ubt_store #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         pass,
    input  logic         hold_n,
    input  logic         rise,
    output logic [W-1:0] word_o
);
    import ubt_pkg::*;

    typedef struct packed {
        logic [W-1:0] word;
    } store_st_t;

    store_st_t  st_d, st_q;
    store_act_e act;

    always_comb begin
        act  = pick_act(pass, hold_n, rise);
        st_d = st_q;
        case (act)
            ACT_FOLLOW:  st_d.word = din;
            ACT_CAPTURE: st_d.word = din;
            default:     st_d.word = st_q.word;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{word: '0};
        else
            st_q <= st_d;
    end

    // Pass-through is combinational; otherwise the held word is shown.
    assign word_o = pass ? din : st_q.word;

    AST_EDGE_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass && !hold_n && rise) |=> (st_q.word == $past(din))); // R3
    AST_QUALIFIER_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass && hold_n) |=> $stable(st_q.word)); // R4
    AST_NO_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass && !rise) |=> $stable(st_q.word)); // R5
    AST_PASS_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        pass |=> (st_q.word == $past(din))); // R6

endmodule

// File: rtl/ubt_drive.sv
module ubt_drive #(
    parameter int W = 18
) (
    input  logic         drv_n,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] dout,
    output logic [W-1:0] oe
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign oe[i]   = ~drv_n;
        assign dout[i] = word_i[i] & ~drv_n;
    end

endmodule

// File: rtl/ubt_transceiver.sv
module ubt_transceiver #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    input  logic         ab_drv_n,
    input  logic         ab_pass,
    input  logic         ab_strobe,
    input  logic         ab_hold_n,
    input  logic         ba_drv_n,
    input  logic         ba_pass,
    input  logic         ba_strobe,
    input  logic         ba_hold_n
);
    localparam int NDIR = 2;

    logic [W-1:0] din_v  [NDIR];
    logic [W-1:0] word_v [NDIR];
    logic [W-1:0] dout_v [NDIR];
    logic [W-1:0] oe_v   [NDIR];
    logic         drv_n_v  [NDIR];
    logic         pass_v   [NDIR];
    logic         strobe_v [NDIR];
    logic         hold_n_v [NDIR];
    logic         rise_v   [NDIR];

    // Index 0: A to B, index 1: B to A.
    assign din_v[0]    = a_in;
    assign din_v[1]    = b_in;
    assign drv_n_v[0]  = ab_drv_n;
    assign drv_n_v[1]  = ba_drv_n;
    assign pass_v[0]   = ab_pass;
    assign pass_v[1]   = ba_pass;
    assign strobe_v[0] = ab_strobe;
    assign strobe_v[1] = ba_strobe;
    assign hold_n_v[0] = ab_hold_n;
    assign hold_n_v[1] = ba_hold_n;

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        ubt_edge_det u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (strobe_v[d]),
            .rise  (rise_v[d])
        );

        ubt_store #(.W(W)) u_store (
            .clk    (clk),
            .rst_n  (rst_n),
            .din    (din_v[d]),
            .pass   (pass_v[d]),
            .hold_n (hold_n_v[d]),
            .rise   (rise_v[d]),
            .word_o (word_v[d])
        );

        ubt_drive #(.W(W)) u_drive (
            .drv_n  (drv_n_v[d]),
            .word_i (word_v[d]),
            .dout   (dout_v[d]),
            .oe     (oe_v[d])
        );
    end

    assign b_out = dout_v[0];
    assign b_oe  = oe_v[0];
    assign a_out = dout_v[1];
    assign a_oe  = oe_v[1];

    AST_AB_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ab_drv_n |-> (b_oe == '0 && b_out == '0)); // R1
    AST_BA_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ba_drv_n |-> (a_oe == '0 && a_out == '0)); // R1
    AST_AB_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_pass && !ab_drv_n) |-> (b_out == a_in)); // R2
    AST_BA_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_pass && !ba_drv_n) |-> (a_out == b_in)); // R2
    AST_AB_OE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe == '0 || b_oe == '1)); // R10
    AST_BA_OE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe == '0 || a_oe == '1)); // R10

endmodule

// File: tb/ubt_transceiver_bench.sv
module ubt_transceiver_bench;
    localparam int W = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [W-1:0] din [2];
    logic drv_n [2];
    logic pass [2];
    logic stb [2];
    logic hold_n [2];
    logic [W-1:0] a_out, a_oe, b_out, b_oe;

    ubt_transceiver #(.W(W)) u_ubt_transceiver (
        .clk(clk), .rst_n(rst_n),
        .a_in(din[0]), .a_out(a_out), .a_oe(a_oe),
        .b_in(din[1]), .b_out(b_out), .b_oe(b_oe),
        .ab_drv_n(drv_n[0]), .ab_pass(pass[0]), .ab_strobe(stb[0]), .ab_hold_n(hold_n[0]),
        .ba_drv_n(drv_n[1]), .ba_pass(pass[1]), .ba_strobe(stb[1]), .ba_hold_n(hold_n[1])
    );

    // Behavioural reference per direction.
    logic [W-1:0] m_word [2];
    logic m_prev [2];
    int checks = 0;
    int errors = 0;
    string req = "R9";

    task automatic compare(input int d);
        logic [W-1:0] exp_d, exp_oe, got_d, got_oe;
        exp_oe = drv_n[d] ? '0 : '1;
        exp_d  = drv_n[d] ? '0 : (pass[d] ? din[d] : m_word[d]);
        got_d  = (d == 0) ? b_out : a_out;
        got_oe = (d == 0) ? b_oe : a_oe;
        checks++;
        if (got_d !== exp_d || got_oe !== exp_oe) begin
            errors++;
            $display("FAIL %s dir%0d: data=%h oe=%h expected data=%h oe=%h",
                     req, d, got_d, got_oe, exp_d, exp_oe);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) begin
            #1;
            compare(0);
            compare(1);
            for (int d = 0; d < 2; d++) begin
                if (pass[d]) m_word[d] = din[d];
                else if (stb[d] && !m_prev[d] && !hold_n[d]) m_word[d] = din[d];
                m_prev[d] = stb[d];
            end
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic set(input int d, input logic o, input logic p,
                       input logic s, input logic h, input logic [W-1:0] v);
        drv_n[d] = o; pass[d] = p; stb[d] = s; hold_n[d] = h; din[d] = v;
    endtask

    task automatic rnd(input int d);
        din[d] = W'($urandom);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, actual running expected done");
        finish_run();
    end

    initial begin
        for (int d = 0; d < 2; d++) begin
            set(d, 1'b0, 1'b0, 1'b1, 1'b0, 18'h2aaaa);
            m_word[d] = '0;
            m_prev[d] = 1'b1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: zero after reset; strobe high at release is no edge.
        req = "R9";
        cyc(3);

        // R1: disabled directions drive nothing.
        req = "R1";
        set(0, 1'b1, 1'b1, 1'b0, 1'b0, 18'h3ffff);
        set(1, 1'b1, 1'b0, 1'b0, 1'b0, 18'h12345);
        for (int k = 0; k < 6; k++) begin
            stb[0] = ~stb[0]; stb[1] = ~stb[1]; rnd(0); rnd(1); cyc(1);
        end

        // R2: transparent, strobe and qualifier toggling.
        req = "R2";
        set(0, 1'b0, 1'b1, 1'b0, 1'b1, 18'h0);
        set(1, 1'b0, 1'b1, 1'b0, 1'b0, 18'h0);
        for (int k = 0; k < 8; k++) begin
            stb[0] = ~stb[0]; hold_n[1] = ~hold_n[1]; rnd(0); rnd(1); cyc(1);
        end

        // R6: close with strobe low; later close with strobe high.
        req = "R6";
        set(0, 1'b0, 1'b1, 1'b0, 1'b0, 18'h1c0de); cyc(1);
        set(0, 1'b0, 1'b0, 1'b0, 1'b0, 18'h00f0f); cyc(2);
        set(0, 1'b0, 1'b1, 1'b1, 1'b0, 18'h0beef); cyc(1);
        set(0, 1'b0, 1'b0, 1'b1, 1'b0, 18'h33333); cyc(3);

        // R3: qualified strobe captures, visible next cycle.
        req = "R3";
        for (int k = 0; k < 6; k++) begin
            stb[0] = 1'b0; rnd(0); cyc(1);
            stb[0] = 1'b1; rnd(0); cyc(1);
            rnd(0); cyc(1);
        end

        // R4: qualifier high blocks edges.
        req = "R4";
        hold_n[0] = 1'b1;
        for (int k = 0; k < 6; k++) begin
            stb[0] = ~stb[0]; rnd(0); cyc(1);
        end

        // R5: steady strobe low then high, data moving.
        req = "R5";
        hold_n[0] = 1'b0; stb[0] = 1'b0;
        for (int k = 0; k < 4; k++) begin rnd(0); cyc(1); end
        stb[0] = 1'b1; rnd(0); cyc(1);
        for (int k = 0; k < 4; k++) begin rnd(0); cyc(1); end

        // R7: drive toggles; disabled path keeps capturing.
        req = "R7";
        for (int k = 0; k < 4; k++) begin drv_n[0] = ~drv_n[0]; rnd(0); cyc(1); end
        set(0, 1'b1, 1'b0, 1'b0, 1'b0, 18'h0); cyc(1);
        set(0, 1'b1, 1'b0, 1'b1, 1'b0, 18'h2d2d2); cyc(1);
        set(0, 1'b0, 1'b0, 1'b0, 1'b0, 18'h11111); cyc(2);
        set(0, 1'b1, 1'b1, 1'b0, 1'b0, 18'h05a5a); cyc(1);
        set(0, 1'b0, 1'b0, 1'b0, 1'b1, 18'h0); cyc(2);

        // R8: different modes on each side at once.
        req = "R8";
        set(0, 1'b0, 1'b0, 1'b0, 1'b0, 18'h0);
        set(1, 1'b0, 1'b1, 1'b0, 1'b0, 18'h0);
        for (int k = 0; k < 10; k++) begin
            stb[0] = ~stb[0]; stb[1] = ~stb[1]; rnd(0); rnd(1);
            if (k == 5) pass[1] = 1'b0;
            cyc(1);
        end

        // R10 is covered by every comparison of the enable vectors.
        req = "R10";
        for (int k = 0; k < 4; k++) begin
            drv_n[1] = ~drv_n[1]; stb[1] = ~stb[1]; rnd(1); cyc(1);
        end

        finish_run();
    end

endmodule